// File: doc/BRIEF.md
# Voice Volume Envelope Generator

This block produces the volume envelope of one audio voice. It advances once per output sample, on cycles where the sample strobe is high. Two per-sample strobes control the voice. Key-on restarts the note. Key-off lets the note die away. Between them the unit moves through four phases: attack, decay, sustain and release. It keeps an 11-bit envelope level that a mixer elsewhere multiplies into the voice's samples.

Key-on silences the voice at once and holds the level at zero for a short start delay before the attack ramp begins. The attack ramp climbs quickly, or in large steps at the fastest attack setting, until it reaches full scale. Decay then falls exponentially toward a programmable sustain threshold, and the level holds there. Key-off always releases in fixed steps, whatever attack setting is programmed. A byte-wide readout of the level is also provided for observation. Its top bit is always clear.

Top module: `voice_env`

## Requirements
- R1: During and after synchronous reset, with no strobe applied, the level is 0, the state is release (encoding attack=0, decay=1, sustain=2, release=3) and the readout byte is 0.
- R2: A sample tick with key-on (and no key-off) sets the level to 0 and the state to attack after that tick. This applies in any state, including during release.
- R3: After a key-on tick, the level stays 0 for the next 5 sample ticks. The first increase comes on the 6th tick after key-on.
- R4: In attack, each tick adds 32 to the level, or 1024 when the attack rate input is 15. The sum clamps at 0x7FF, and the tick that reaches 0x7FF moves the state to decay.
- R5: In decay, each tick subtracts ((level-1)>>8)+1. The tick whose result is at or below the sustain threshold moves the state to sustain, and sustain then holds the level constant.
- R6: A key-off tick moves any state to release and leaves the level unchanged on that tick. Each later tick in release subtracts 8, clamped at 0, and the level stays 0 until the next key-on.
- R7: Key-on and key-off on the same tick give state release and level 0.
- R8: The readout byte equals {0, level[10:4]}, so its bit 7 is always 0.
- R9: On cycles with the sample tick low, all inputs are ignored: level and state do not change, even if key strobes are high.
- R10: Key-off during the key-on start delay goes to release with level 0, and the level stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe, one cycle per output sample |
| key_on | input | 1 | Note start strobe, honoured only with tick |
| key_off | input | 1 | Note release strobe, honoured only with tick |
| atk_rate | input | 4 | Attack rate; 15 selects the fast step |
| sus_lvl | input | 11 | Sustain threshold for the decay phase |
| env_level | output | 11 | Current envelope level |
| env_state | output | 2 | Phase: 0 attack, 1 decay, 2 sustain, 3 release |
| env_rd | output | 8 | Readout byte {0, level[10:4]} |

## Verification
Level, state and readout are all registered. Each tick's result therefore appears one clock after the edge that sees the strobe, and the bench checks it at the following falling edge, after it has dropped the strobe. The start delay is counted in ticks, not clocks, so the first non-zero attack level is expected on the sixth strobed edge after key-on. A reference model in the bench steps once per applied tick, so idle cycles between ticks must show no change. The fixed table, the decay-to-sustain run, the long release to zero and a pseudo-random key sweep are all compared at exactly that sample point.

// File: rtl/env_pkg.sv
package env_pkg;

    typedef enum logic [1:0] {
        ST_ATTACK  = 2'd0,
        ST_DECAY   = 2'd1,
        ST_SUSTAIN = 2'd2,
        ST_RELEASE = 2'd3
    } env_state_e;

    typedef struct packed {
        logic on;
        logic off;
    } key_req_t;

    // Phase a key request forces; the release request dominates.
    function automatic env_state_e key_target(env_state_e cur, key_req_t k);
        if (k.off)
            return ST_RELEASE;
        else if (k.on)
            return ST_ATTACK;
        else
            return cur;
    endfunction

    function automatic logic key_any(key_req_t k);
        return k.on | k.off;
    endfunction

endpackage

// File: rtl/env_keyctl.sv
module env_keyctl
    import env_pkg::*;
#(
    parameter int START_DLY = 5,
    localparam int DLY_W = $clog2(START_DLY + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  key_req_t   keys,
    input  logic       peak_hit,
    input  logic       sus_hit,
    output env_state_e state,
    output logic       dly_busy
);

    logic [DLY_W-1:0] dly_cnt;

    assign dly_busy = (dly_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RELEASE;
            dly_cnt <= '0;
        end else if (tick) begin
            if (key_any(keys)) begin
                state   <= key_target(state, keys);
                dly_cnt <= keys.off ? '0 : DLY_W'(START_DLY);
            end else begin
                case (state)
                    ST_ATTACK: begin
                        if (dly_busy)
                            dly_cnt <= dly_cnt - 1'b1;
                        else if (peak_hit)
                            state <= ST_DECAY;
                    end
                    ST_DECAY: begin
                        if (sus_hit)
                            state <= ST_SUSTAIN;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: the start delay counts down by one per idle tick
    p_delay_count_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !key_any(keys) && dly_busy) |=> (dly_cnt == $past(dly_cnt) - 1'b1));

    // R3: a fresh key-on loads the full delay
    p_delay_load_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && keys.on && !keys.off) |=> (dly_cnt == DLY_W'(START_DLY)));

endmodule

// File: rtl/env_level_calc.sv
module env_level_calc
    import env_pkg::*;
#(
    parameter int LVL_W       = 11,
    parameter int RATE_W      = 4,
    parameter int ATK_SLOW    = 32,
    parameter int ATK_FAST    = 1024,
    parameter int REL_STEP    = 8,
    parameter int DECAY_SHIFT = 8
) (
    input  env_state_e        state,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [RATE_W-1:0] rate,
    input  logic [LVL_W-1:0]  sus,
    input  logic              busy,
    output logic [LVL_W-1:0]  nxt,
    output logic              peak_hit,
    output logic              sus_hit
);

    localparam logic [LVL_W-1:0] LVL_MAX   = {LVL_W{1'b1}};
    localparam logic [LVL_W:0]   STEP_SLOW = (LVL_W+1)'(ATK_SLOW);
    localparam logic [LVL_W:0]   STEP_FAST = (LVL_W+1)'(ATK_FAST);
    localparam logic [LVL_W-1:0] STEP_REL  = LVL_W'(REL_STEP);

    logic [LVL_W:0]   atk_sum;
    logic [LVL_W-1:0] lvl_m1;
    logic [LVL_W-1:0] dec_step;
    logic [LVL_W-1:0] dec_val;
    logic [LVL_W-1:0] rel_val;

    always_comb begin
        atk_sum  = {1'b0, lvl} + ((rate == {RATE_W{1'b1}}) ? STEP_FAST : STEP_SLOW);
        lvl_m1   = lvl - LVL_W'(1);
        dec_step = (lvl_m1 >> DECAY_SHIFT) + LVL_W'(1);
        dec_val  = (lvl == '0) ? '0 : lvl - dec_step;
        rel_val  = (lvl >= STEP_REL) ? lvl - STEP_REL : '0;

        nxt      = lvl;
        peak_hit = 1'b0;
        sus_hit  = 1'b0;
        case (state)
            ST_ATTACK: begin
                if (!busy) begin
                    if (atk_sum >= {1'b0, LVL_MAX}) begin
                        nxt      = LVL_MAX;
                        peak_hit = 1'b1;
                    end else begin
                        nxt = atk_sum[LVL_W-1:0];
                    end
                end
            end
            ST_DECAY: begin
                nxt     = dec_val;
                sus_hit = (dec_val <= sus);
            end
            ST_SUSTAIN: nxt = lvl;
            default:    nxt = rel_val;
        endcase
    end

endmodule

// File: rtl/voice_env.sv
module voice_env
    import env_pkg::*;
#(
    parameter int LVL_W       = 11,
    parameter int RATE_W      = 4,
    parameter int START_DLY   = 5,
    parameter int ATK_SLOW    = 32,
    parameter int ATK_FAST    = 1024,
    parameter int REL_STEP    = 8,
    parameter int DECAY_SHIFT = 8,
    parameter int RD_SHIFT    = 4,
    localparam int RD_W       = LVL_W - RD_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              key_on,
    input  logic              key_off,
    input  logic [RATE_W-1:0] atk_rate,
    input  logic [LVL_W-1:0]  sus_lvl,
    output logic [LVL_W-1:0]  env_level,
    output logic [1:0]        env_state,
    output logic [RD_W-1:0]   env_rd
);

    key_req_t         keys;
    env_state_e       state;
    logic             dly_busy;
    logic             peak_hit;
    logic             sus_hit;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] lvl_nxt;

    assign keys = '{on: key_on, off: key_off};

    env_keyctl #(.START_DLY(START_DLY)) u_keyctl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .keys     (keys),
        .peak_hit (peak_hit),
        .sus_hit  (sus_hit),
        .state    (state),
        .dly_busy (dly_busy)
    );

    env_level_calc #(
        .LVL_W       (LVL_W),
        .RATE_W      (RATE_W),
        .ATK_SLOW    (ATK_SLOW),
        .ATK_FAST    (ATK_FAST),
        .REL_STEP    (REL_STEP),
        .DECAY_SHIFT (DECAY_SHIFT)
    ) u_calc (
        .state    (state),
        .lvl      (lvl_q),
        .rate     (atk_rate),
        .sus      (sus_lvl),
        .busy     (dly_busy),
        .nxt      (lvl_nxt),
        .peak_hit (peak_hit),
        .sus_hit  (sus_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= '0;
        else if (tick) begin
            if (keys.on)
                lvl_q <= '0;
            else if (!keys.off)
                lvl_q <= lvl_nxt;
        end
    end

    assign env_level = lvl_q;
    assign env_state = state;

    // Readout drops the low bits and always shows a clear top bit.
    generate
        if (RD_SHIFT > 0) begin : g_rd_shift
            assign env_rd = {1'b0, lvl_q[LVL_W-1:RD_SHIFT]};
        end else begin : g_rd_full
            assign env_rd = {1'b0, lvl_q};
        end
    endgenerate

    // R9: nothing moves between sample ticks
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(env_level) && $stable(env_state)));

    // R2: key-on alone silences and enters attack
    p_keyon_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && key_on && !key_off) |=> (env_level == '0 && env_state == ST_ATTACK));

    // R7: both strobes give a silent release
    p_both_keys_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && key_on && key_off) |=> (env_level == '0 && env_state == ST_RELEASE));

    // R6: key-off always lands in release
    p_keyoff_release_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && key_off) |=> (env_state == ST_RELEASE));

    // R6: release steps down by a fixed amount and floors at zero
    p_release_step_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !key_on && !key_off && env_state == ST_RELEASE) |=>
        (($past(env_level) >= LVL_W'(REL_STEP)) ?
            (env_level == $past(env_level) - LVL_W'(REL_STEP)) : (env_level == '0)));

    // R3: level is silent while the start delay runs
    p_delay_silent_r3: assert property (@(posedge clk) disable iff (rst)
        dly_busy |-> (env_level == '0));

    // R5: decay never raises the level
    p_decay_down_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !key_on && !key_off && env_state == ST_DECAY) |=> (env_level <= $past(env_level)));

endmodule

// File: tb/tb_voice_env.sv
module tb_voice_env;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        key_on = 1'b0;
    logic        key_off = 1'b0;
    logic [3:0]  atk_rate = 4'd0;
    logic [10:0] sus_lvl = 11'd0;
    logic [10:0] env_level;
    logic [1:0]  env_state;
    logic [7:0]  env_rd;

    always #2 clk = ~clk;  // 250 MHz

    voice_env dut (
        .clk(clk), .rst(rst), .tick(tick), .key_on(key_on), .key_off(key_off),
        .atk_rate(atk_rate), .sus_lvl(sus_lvl),
        .env_level(env_level), .env_state(env_state), .env_rd(env_rd)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // vector: kon, koff, rate[3:0], sus[10:0], exp_level[10:0], exp_state[1:0]
    function automatic logic [29:0] mkv(bit kon, bit koff, int rate, int sus, int lvl, int st);
        return {kon, koff, 4'(rate), 11'(sus), 11'(lvl), 2'(st)};
    endfunction

    localparam int NV = 24;
    localparam logic [29:0] VEC [0:NV-1] = '{
        mkv(1,0,15,'h600,   0,0),  // R2 key-on
        mkv(0,0,15,'h600,   0,0),  // R3 delay 1
        mkv(0,0,15,'h600,   0,0),
        mkv(0,0,15,'h600,   0,0),
        mkv(0,0,15,'h600,   0,0),
        mkv(0,0,15,'h600,   0,0),  // R3 delay 5
        mkv(0,0,15,'h600,1024,0),  // R4 fast step
        mkv(0,0,15,'h600,2047,1),  // R4 clamp, to decay
        mkv(0,0,15,'h600,2039,1),  // R5 step 8
        mkv(0,0,15,'h600,2031,1),
        mkv(0,1,15,'h600,2031,3),  // R6 key-off holds level
        mkv(0,0,15,'h600,2023,3),  // R6 minus 8
        mkv(1,1,15,'h600,   0,3),  // R7 both
        mkv(0,0,15,'h600,   0,3),
        mkv(1,0, 0,'h600,   0,0),  // R2 restart, slow rate
        mkv(0,0, 0,'h600,   0,0),
        mkv(0,0, 0,'h600,   0,0),
        mkv(0,0, 0,'h600,   0,0),
        mkv(0,0, 0,'h600,   0,0),
        mkv(0,0, 0,'h600,   0,0),
        mkv(0,0, 0,'h600,  32,0),  // R4 slow step
        mkv(0,0, 0,'h600,  64,0),
        mkv(0,1, 0,'h600,  64,3),  // R6
        mkv(0,0, 0,'h600,  56,3)
    };

    // reference model
    int m_lvl = 0;
    int m_st  = 3;
    int m_cnt = 0;

    task automatic model_step(bit kon, bit koff, int rate, int sus);
        if (koff) begin
            m_st = 3; m_cnt = 0;
            if (kon) m_lvl = 0;
        end else if (kon) begin
            m_st = 0; m_cnt = 5; m_lvl = 0;
        end else begin
            case (m_st)
                0: if (m_cnt > 0) m_cnt--;
                   else begin
                       m_lvl = m_lvl + ((rate == 15) ? 1024 : 32);
                       if (m_lvl >= 2047) begin m_lvl = 2047; m_st = 1; end
                   end
                1: begin
                       if (m_lvl > 0) m_lvl = m_lvl - (((m_lvl - 1) >> 8) + 1);
                       if (m_lvl <= sus) m_st = 2;
                   end
                2: ;
                default: m_lvl = (m_lvl >= 8) ? m_lvl - 8 : 0;
            endcase
        end
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; result is read at the next falling edge
    task automatic apply(bit kon, bit koff, int rate, int sus);
        tick = 1'b1; key_on = kon; key_off = koff;
        atk_rate = 4'(rate); sus_lvl = 11'(sus);
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; key_on = 1'b0; key_off = 1'b0;
        model_step(kon, koff, rate, sus);
    endtask

    task automatic check_model(string req);
        check({req, " level"}, int'(env_level), m_lvl);
        check({req, " state"}, int'(env_state), m_st);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 level", int'(env_level), 0);
        check("R1 state", int'(env_state), 3);
        check("R1 readout", int'(env_rd), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 state after release of reset", int'(env_state), 3);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            apply(v[29], v[28], int'(v[27:24]), int'(v[23:13]));
            check($sformatf("table %0d level (R2-R7)", i), int'(env_level), int'(v[12:2]));
            check($sformatf("table %0d state (R2-R7)", i), int'(env_state), int'(v[1:0]));
        end

        // R9: strobes without tick are ignored
        apply(1, 0, 0, 'h600);
        for (int i = 0; i < 8; i++) apply(0, 0, 0, 'h600);
        check_model("R9 setup");
        key_off = 1'b1; key_on = 1'b1;
        repeat (3) @(negedge clk);
        key_off = 1'b0; key_on = 1'b0;
        check("R9 level held", int'(env_level), 96);
        check("R9 state held", int'(env_state), 0);

        // R5: decay to sustain and hold; R8 readout at full scale
        apply(1, 0, 15, 'h7C0);
        for (int i = 0; i < 7; i++) apply(0, 0, 15, 'h7C0);
        check("R8 readout at peak", int'(env_rd), 'h7F);
        check("R8 readout bit7", int'(env_rd[7]), 0);
        for (int i = 0; i < 12; i++) begin
            apply(0, 0, 15, 'h7C0);
            check_model("R5 decay");
        end
        check("R5 sustain reached", int'(env_state), 2);
        check("R5 sustain level", int'(env_level), 1983);
        check("R8 readout", int'(env_rd), 1983 >> 4);

        // R6: release all the way to zero and stay there
        apply(0, 1, 15, 'h7C0);
        for (int i = 0; i < 300; i++) begin
            apply(0, 0, 15, 'h7C0);
            check_model("R6 release");
        end
        check("R6 floor", int'(env_level), 0);

        // R10: key-off inside the start delay
        apply(1, 0, 15, 'h100);
        apply(0, 0, 15, 'h100);
        apply(0, 1, 15, 'h100);
        for (int i = 0; i < 6; i++) apply(0, 0, 15, 'h100);
        check("R10 level", int'(env_level), 0);
        check("R10 state", int'(env_state), 3);

        // mixed sweep against the model
        lf = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            bit kon, koff;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            kon  = (lf[4:0] == 5'd3);
            koff = (lf[9:5] == 5'd7);
            apply(kon, koff, lf[11] ? 15 : int'(lf[15:12]), int'({lf[2:0], 8'h40}));
            check_model("R2 R4 R5 R6 sweep");
        end

        // R1: reset from a live state
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset level", int'(env_level), 0);
        check("R1 reset state", int'(env_state), 3);
        rst = 1'b0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule